// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This block makes the special-case decision for a fused multiply-add unit that computes a*b+c. It is given a class code for each of the three operands, a default-NaN-mode bit and a policy select. It reports whether a special case applies, meaning that some operand is a NaN or that the product is infinity times zero. When one applies, the block names which value becomes the result: operand a, operand b, operand c, or the canonical default NaN. It also raises the invalid-operation flag, together with two sub-flags that say why.

The infinity-times-zero flag is produced on its own, apart from any policy, so every ordering raises it in the same way. The policy input picks one of several NaN-priority orderings. A datapath mux outside this block uses the selection code. All outputs are registered and cleared by a synchronous active-high reset.

Top module: `fma_nan_sel`

## Requirements
- R1: Every output is registered. The result for inputs applied before a rising clock edge appears after that edge. While `rst` is high at an edge, every output becomes 0.
- R2: Class codes are 0 for zero, 1 for normal, 2 for infinity, 3 for quiet NaN and 4 for signalling NaN. If any operand has code 4, `invalid` and `inv_snan` are both 1. Otherwise `inv_snan` is 0.
- R3: If one of a and b has code 2 and the other has code 0, in either order, `invalid` and `inv_imz` are both 1. This holds for every policy and every value of `dflt_mode`. Otherwise `inv_imz` is 0.
- R4: If no operand is a NaN and infinity times zero does not hold, then `special`, `res_sel` and all three flags are 0. In every other case `special` is 1, and `invalid` is 1 exactly when `inv_snan` or `inv_imz` is 1.
- R5: `res_sel` uses 0 for a, 1 for b, 2 for c and 3 for the default NaN. In a special case with `dflt_mode` at 1, `res_sel` is 3. In a special case where the policy finds no NaN operand, `res_sel` is 3.
- R6: Policy 0 returns 3 when infinity times zero holds and c is a quiet NaN. Otherwise it takes the first signalling NaN in the order a, b, c. If there is none, it takes the first quiet NaN in that same order.
- R7: Policy 1 returns 3 whenever infinity times zero holds. Otherwise it searches the same way as R6.
- R8: Policy 2 searches for a signalling NaN first and then for a quiet NaN, in both passes trying c, then a, then b.
- R9: Policy 3 searches for a signalling NaN first and then for a quiet NaN, in both passes trying c, then b, then a.
- R10: Policies 4 to 7 return 3 in every special case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_cls | input | 3 | Class code of multiplicand a |
| b_cls | input | 3 | Class code of multiplicand b |
| c_cls | input | 3 | Class code of addend c |
| dflt_mode | input | 1 | Force the default NaN in special cases |
| policy | input | 3 | NaN-priority policy select |
| special | output | 1 | A special case applies |
| res_sel | output | 2 | Result selection code |
| invalid | output | 1 | Invalid-operation flag |
| inv_snan | output | 1 | Invalid because of a signalling NaN operand |
| inv_imz | output | 1 | Invalid because of infinity times zero |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench drives each input set on a falling edge and compares all outputs on the next falling edge. That sample point sits half a period after the register loads and before any newer input can reach the outputs. The bench walks every class triple under every policy with default-NaN mode both off and on. It checks each case against a behavioural model that searches an ordered operand list, and it checks the reset clear with special-case inputs held.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;
  localparam int CLS_W = 3;
  localparam int N_OPS = 3;
  localparam int SEL_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CL_ZERO = 3'd0,
    CL_NORM = 3'd1,
    CL_INF  = 3'd2,
    CL_QNAN = 3'd3,
    CL_SNAN = 3'd4
  } cls_e;

  typedef enum logic [SEL_W-1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_e;

  typedef struct packed {
    logic [N_OPS-1:0] qn;
    logic [N_OPS-1:0] sn;
    logic             infzero;
  } cls_info_t;
endpackage

// File: rtl/fma_nan_classify.sv
module fma_nan_classify
  import fma_nan_pkg::*;
#(
  parameter int OPS = N_OPS
) (
  input  logic [OPS*CLS_W-1:0] cls_flat,
  output cls_info_t            info
);
  logic [OPS-1:0] is_inf, is_zero;

  genvar gi;
  generate
    for (gi = 0; gi < OPS; gi++) begin : g_op
      logic [CLS_W-1:0] code;
      assign code          = cls_flat[gi*CLS_W +: CLS_W];
      assign info.qn[gi]   = (code == CL_QNAN);
      assign info.sn[gi]   = (code == CL_SNAN);
      assign is_inf[gi]    = (code == CL_INF);
      assign is_zero[gi]   = (code == CL_ZERO);
    end
  endgenerate

  // product operands are indices 0 (a) and 1 (b)
  assign info.infzero = (is_inf[0] & is_zero[1]) | (is_zero[0] & is_inf[1]);
endmodule

// File: rtl/fma_nan_prio.sv
module fma_nan_prio
  import fma_nan_pkg::*;
#(
  parameter int FIRST  = 0,
  parameter int SECOND = 1,
  parameter int THIRD  = 2
) (
  input  logic [N_OPS-1:0] sn,
  input  logic [N_OPS-1:0] qn,
  output logic             found,
  output logic [SEL_W-1:0] idx
);
  localparam int ORD [N_OPS] = '{FIRST, SECOND, THIRD};

  // lowest-priority candidates are written first and later ones overwrite
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N_OPS-1; k >= 0; k--) begin
      if (qn[ORD[k]]) begin
        found = 1'b1;
        idx   = SEL_W'(ORD[k]);
      end
    end
    for (int k = N_OPS-1; k >= 0; k--) begin
      if (sn[ORD[k]]) begin
        found = 1'b1;
        idx   = SEL_W'(ORD[k]);
      end
    end
  end
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
  import fma_nan_pkg::*;
#(
  parameter int POL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CLS_W-1:0] a_cls,
  input  logic [CLS_W-1:0] b_cls,
  input  logic [CLS_W-1:0] c_cls,
  input  logic             dflt_mode,
  input  logic [POL_W-1:0] policy,
  output logic             special,
  output logic [SEL_W-1:0] res_sel,
  output logic             invalid,
  output logic             inv_snan,
  output logic             inv_imz
);
  cls_info_t        info;
  logic             f_abc, f_cab, f_cba;
  logic [SEL_W-1:0] i_abc, i_cab, i_cba;
  logic             spec_c;
  logic [SEL_W-1:0] pick_c;

  fma_nan_classify #(.OPS(N_OPS)) u_cls (
    .cls_flat ({c_cls, b_cls, a_cls}),
    .info     (info)
  );

  fma_nan_prio #(.FIRST(0), .SECOND(1), .THIRD(2)) u_abc (
    .sn(info.sn), .qn(info.qn), .found(f_abc), .idx(i_abc));
  fma_nan_prio #(.FIRST(2), .SECOND(0), .THIRD(1)) u_cab (
    .sn(info.sn), .qn(info.qn), .found(f_cab), .idx(i_cab));
  fma_nan_prio #(.FIRST(2), .SECOND(1), .THIRD(0)) u_cba (
    .sn(info.sn), .qn(info.qn), .found(f_cba), .idx(i_cba));

  assign spec_c = (|info.qn) | (|info.sn) | info.infzero;

  always_comb begin
    unique case (policy)
      POL_W'(0): pick_c = (info.infzero && info.qn[2]) ? PICK_DFLT
                          : (f_abc ? i_abc : PICK_DFLT);
      POL_W'(1): pick_c = info.infzero ? PICK_DFLT
                          : (f_abc ? i_abc : PICK_DFLT);
      POL_W'(2): pick_c = f_cab ? i_cab : PICK_DFLT;
      POL_W'(3): pick_c = f_cba ? i_cba : PICK_DFLT;
      default:   pick_c = PICK_DFLT;
    endcase
    if (dflt_mode) pick_c = PICK_DFLT;
    if (!spec_c)   pick_c = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      special  <= 1'b0;
      res_sel  <= '0;
      invalid  <= 1'b0;
      inv_snan <= 1'b0;
      inv_imz  <= 1'b0;
    end else begin
      special  <= spec_c;
      res_sel  <= pick_c;
      inv_snan <= |info.sn;
      inv_imz  <= info.infzero;
      invalid  <= (|info.sn) | info.infzero;
    end
  end
endmodule

// File: rtl/fma_nan_sel_chk.sv
module fma_nan_sel_chk
  import fma_nan_pkg::*;
#(
  parameter int POL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CLS_W-1:0] a_cls,
  input logic [CLS_W-1:0] b_cls,
  input logic [CLS_W-1:0] c_cls,
  input logic             dflt_mode,
  input logic [POL_W-1:0] policy,
  input logic             special,
  input logic [SEL_W-1:0] res_sel,
  input logic             invalid,
  input logic             inv_snan,
  input logic             inv_imz
);
  logic any_sn, any_nan, imz_in;
  assign any_sn  = (a_cls == 3'd4) || (b_cls == 3'd4) || (c_cls == 3'd4);
  assign any_nan = any_sn || (a_cls == 3'd3) || (b_cls == 3'd3) || (c_cls == 3'd3);
  assign imz_in  = ((a_cls == 3'd2) && (b_cls == 3'd0)) || ((a_cls == 3'd0) && (b_cls == 3'd2));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!special && res_sel == '0 && !invalid && !inv_snan && !inv_imz)); // R1
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (rst)
    any_sn |=> (invalid && inv_snan)); // R2
  AST_IMZ_FLAG: assert property (@(posedge clk) disable iff (rst)
    imz_in |=> (invalid && inv_imz)); // R3
  AST_QUIET_CASE: assert property (@(posedge clk) disable iff (rst)
    (!any_nan && !imz_in) |=> (!special && res_sel == '0 && !invalid)); // R4
  AST_INVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (inv_snan || inv_imz)); // R4
  AST_DFLT_MODE: assert property (@(posedge clk) disable iff (rst)
    (dflt_mode && (any_nan || imz_in)) |=> (res_sel == 2'd3)); // R5
  AST_ALWAYS_DFLT: assert property (@(posedge clk) disable iff (rst)
    ((policy >= POL_W'(4)) && (any_nan || imz_in)) |=> (res_sel == 2'd3)); // R10
endmodule

bind fma_nan_sel fma_nan_sel_chk #(.POL_W(POL_W)) i_chk (
  .clk(clk), .rst(rst), .a_cls(a_cls), .b_cls(b_cls), .c_cls(c_cls),
  .dflt_mode(dflt_mode), .policy(policy), .special(special), .res_sel(res_sel),
  .invalid(invalid), .inv_snan(inv_snan), .inv_imz(inv_imz)
);

// File: tb/test_fma_nan_sel.sv
`timescale 1ns/1ps
module test_fma_nan_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] a_cls = 3'd0, b_cls = 3'd0, c_cls = 3'd0;
  logic       dflt_mode = 1'b0;
  logic [2:0] policy = 3'd0;
  logic       special, invalid, inv_snan, inv_imz;
  logic [1:0] res_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  fma_nan_sel i_fma_nan_sel (
    .clk(clk), .rst(rst), .a_cls(a_cls), .b_cls(b_cls), .c_cls(c_cls),
    .dflt_mode(dflt_mode), .policy(policy), .special(special), .res_sel(res_sel),
    .invalid(invalid), .inv_snan(inv_snan), .inv_imz(inv_imz)
  );

  // behavioural reference: returns {special, sel[1:0], invalid, snan, imz}
  function automatic logic [5:0] model(int a, int b, int c, bit dm, int pol);
    int cls[3];
    int ord[3];
    bit sn, nan, iz, spec;
    int sel;
    cls[0] = a; cls[1] = b; cls[2] = c;
    sn  = (a == 4) || (b == 4) || (c == 4);
    nan = sn || (a == 3) || (b == 3) || (c == 3);
    iz  = (a == 2 && b == 0) || (a == 0 && b == 2);
    spec = nan || iz;
    sel = 3;
    case (pol)
      2: ord = '{2, 0, 1};
      3: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    if (pol <= 3) begin
      int hit;
      hit = -1;
      foreach (ord[k]) if (hit < 0 && cls[ord[k]] == 4) hit = ord[k];
      foreach (ord[k]) if (hit < 0 && cls[ord[k]] == 3) hit = ord[k];
      if (hit >= 0) sel = hit;
      if (pol == 0 && iz && c == 3) sel = 3;
      if (pol == 1 && iz) sel = 3;
    end
    if (dm) sel = 3;
    if (!spec) sel = 0;
    return {spec, 2'(sel), sn || iz, sn, iz};
  endfunction

  function automatic string tag_of(logic [5:0] got, logic [5:0] exp, bit dm, int pol);
    if (got[1] != exp[1]) return "R2";
    if (got[0] != exp[0]) return "R3";
    if (got[5] != exp[5] || got[2] != exp[2]) return "R4";
    if (dm) return "R5";
    case (pol)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [5:0] got, logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d c=%0d dm=%0b pol=%0d got=%b exp=%b",
               req, a_cls, b_cls, c_cls, dflt_mode, policy, got, exp);
    end
  endtask

  initial begin
    // R1: reset clears outputs even with special-case inputs held
    a_cls = 3'd4; b_cls = 3'd2; c_cls = 3'd3; policy = 3'd1;
    repeat (3) @(negedge clk);
    check("R1", {special, res_sel, invalid, inv_snan, inv_imz}, 6'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {special, res_sel, invalid, inv_snan, inv_imz}, model(4, 2, 3, 0, 1));
    for (int pol = 0; pol < 8; pol++) begin
      for (int dm = 0; dm < 2; dm++) begin
        for (int a = 0; a < 5; a++) begin
          for (int b = 0; b < 5; b++) begin
            for (int c = 0; c < 5; c++) begin
              logic [5:0] exp, got;
              a_cls = 3'(a); b_cls = 3'(b); c_cls = 3'(c);
              dflt_mode = dm[0]; policy = 3'(pol);
              exp = model(a, b, c, dm[0], pol);
              @(negedge clk);
              got = {special, res_sel, invalid, inv_snan, inv_imz};
              check(tag_of(got, exp, dm[0], pol), got, exp);
            end
          end
        end
      end
    end
    // R1: reset asserted mid-run clears again
    rst = 1'b1;
    @(negedge clk);
    check("R1", {special, res_sel, invalid, inv_snan, inv_imz}, 6'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule